// File: doc/BRIEF.md
# Finite-Difference Polynomial Tabulator

This block steps through a table of polynomial values of degree zero to six, using additions only. It keeps one register for the current function value and one register for each order of difference. Software works out the starting value and the forward differences at n = 0 and writes them all at once through a load strobe. The block shows that starting value as entry zero of the table.

Each accepted step pulse then adds every difference register into the register one order below it. All of these additions happen together and use the values from before the step. The new value leaves the block with a one-cycle valid strobe and a running step index. A degree input chooses how many difference orders take part, and the orders above it are forced to zero.

Arithmetic wraps modulo 2^WIDTH. A sticky flag records any two's-complement overflow of the value adder.

Top module: `poly_tabulator`

## Requirements
- R1: After reset, value_o, index_o, valid_o and ovf_o are all zero.
- R2: A load pulse sets these outputs in the next cycle: value_o equals init_val_i, index_o is 0, valid_o is high and ovf_o is cleared.
- R3: An accepted step makes the new value_o equal to the old value plus the old first difference, taken modulo 2^WIDTH.
- R4: On an accepted step, every difference order k below the highest becomes its old value plus the old order k+1 value. The highest order keeps its value. Loading f=41, d1=2, d2=2 therefore gives 41, 43, 47, 53, 61.
- R5: Difference order k (k = 1..6) is loaded from bits [k*WIDTH-1:(k-1)*WIDTH] of init_diff_i when k is at most the degree, and is loaded as zero otherwise.
- R6: A degree_i value above 6 is treated as 6.
- R7: index_o goes up by one on each accepted step and returns to 0 on a load.
- R8: valid_o is high for exactly one cycle after each load or accepted step. In any other cycle it is low, and value_o and index_o hold.
- R9: ovf_o is set when an accepted step causes signed overflow of the value adder, meaning both operands have the same sign and the sum has the other sign. It stays set until the next load or reset.
- R10: When load_i and step_i are both high in the same cycle, the load takes effect and the step is discarded.
- R11: Step pulses that arrive after reset but before the first load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Writes the start value and the differences |
| init_val_i | input | WIDTH | Start value f(0) |
| init_diff_i | input | MAX_DEG*WIDTH | Start differences; order k is in slice k-1 |
| degree_i | input | DEG_W | Polynomial degree, sampled on load |
| step_i | input | 1 | Advance the table by one entry |
| value_o | output | WIDTH | Current table value |
| valid_o | output | 1 | One-cycle strobe for a new value |
| index_o | output | IDX_W | Step count since the last load |
| ovf_o | output | 1 | Sticky signed-overflow flag |

## Verification
The bench derives the start differences from the coefficients itself. It then compares 64 steps of a sixth-degree polynomial against direct evaluation, so a stage that read a neighbour's updated value instead of its old one would fall off the curve within a few entries. Further scenarios load garbage into the orders above the degree and use a degree of 7: leaking unused orders or failing to clamp the degree would bend a linear or sixth-degree table. Other scenarios cover a positive-to-negative crossing that must raise the flag and keep it set, a load and a step in the same cycle where a design that let the step win would show index 1, and steps before any load that a careless controller would let advance from zero.

// File: rtl/poly_tab_pkg.sv
package poly_tab_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_ADV  = 2'd2
  } op_e;

  function automatic int deg_bits(int max_deg);
    return $clog2(max_deg + 1);
  endfunction
endpackage

// File: rtl/poly_step_ctrl.sv
module poly_step_ctrl
  import poly_tab_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output op_e              op_o,
  output logic [IDX_W-1:0] index_o,
  output logic             valid_o
);
  logic             armed_q, armed_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d;
  op_e              op;

  always_comb begin
    if (load_i)                 op = OP_LOAD;
    else if (step_i && armed_q) op = OP_ADV;
    else                        op = OP_HOLD;
  end

  always_comb begin
    armed_d = armed_q;
    idx_d   = idx_q;
    vld_d   = 1'b0;
    case (op)
      OP_LOAD: begin
        armed_d = 1'b1;
        idx_d   = '0;
        vld_d   = 1'b1;
      end
      OP_ADV: begin
        idx_d = idx_q + 1'b1;
        vld_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      idx_q   <= idx_d;
      vld_q   <= vld_d;
    end
  end

  assign op_o    = op;
  assign index_o = idx_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/poly_diff_stage.sv
module poly_diff_stage
  import poly_tab_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int ORDER = 1,
  parameter int DEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [DEG_W-1:0] deg,
  input  logic [WIDTH-1:0] init,
  input  logic [WIDTH-1:0] upper,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_r, d;
  logic             en;

  assign en = (op != OP_HOLD);

  always_comb begin
    case (op)
      OP_LOAD: d = (int'(deg) >= ORDER) ? init : '0;
      OP_ADV:  d = q_r + upper;
      default: d = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/poly_value_stage.sv
module poly_value_stage
  import poly_tab_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op,
  input  logic [WIDTH-1:0] init,
  input  logic [WIDTH-1:0] diff1,
  output logic [WIDTH-1:0] q,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] q_r, q_d, sum;
  logic             ovf_r, ovf_d, sov, en;

  assign sum = q_r + diff1;
  assign sov = (q_r[MSB] == diff1[MSB]) && (sum[MSB] != q_r[MSB]);
  assign en  = (op != OP_HOLD);

  always_comb begin
    q_d   = q_r;
    ovf_d = ovf_r;
    case (op)
      OP_LOAD: begin
        q_d   = init;
        ovf_d = 1'b0;
      end
      OP_ADV: begin
        q_d   = sum;
        ovf_d = ovf_r | sov;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      ovf_r <= 1'b0;
    end else if (en) begin
      q_r   <= q_d;
      ovf_r <= ovf_d;
    end
  end

  assign q   = q_r;
  assign ovf = ovf_r;
endmodule

// File: rtl/poly_tabulator.sv
module poly_tabulator
  import poly_tab_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int MAX_DEG = 6,
  parameter int IDX_W   = 16,
  localparam int DEG_W  = deg_bits(MAX_DEG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [WIDTH-1:0]         init_val_i,
  input  logic [MAX_DEG*WIDTH-1:0] init_diff_i,
  input  logic [DEG_W-1:0]         degree_i,
  input  logic                     step_i,
  output logic [WIDTH-1:0]         value_o,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         index_o,
  output logic                     ovf_o
);
  op_e              op;
  logic [DEG_W-1:0] deg_eff;
  logic [WIDTH-1:0] diff_q [MAX_DEG];

  assign deg_eff = (int'(degree_i) > MAX_DEG) ? DEG_W'(MAX_DEG) : degree_i;

  poly_step_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .step_i  (step_i),
    .op_o    (op),
    .index_o (index_o),
    .valid_o (valid_o)
  );

  for (genvar k = 0; k < MAX_DEG; k++) begin : g_ord
    logic [WIDTH-1:0] upper;
    if (k == MAX_DEG - 1) begin : g_top
      assign upper = '0;
    end else begin : g_mid
      assign upper = diff_q[k+1];
    end
    poly_diff_stage #(.WIDTH(WIDTH), .ORDER(k + 1), .DEG_W(DEG_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .deg   (deg_eff),
      .init  (init_diff_i[k*WIDTH +: WIDTH]),
      .upper (upper),
      .q     (diff_q[k])
    );
  end

  poly_value_stage #(.WIDTH(WIDTH)) u_value (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .init  (init_val_i),
    .diff1 (diff_q[0]),
    .q     (value_o),
    .ovf   (ovf_o)
  );
endmodule

// File: rtl/poly_tabulator_chk.sv
module poly_tabulator_chk
  import poly_tab_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             step_i,
  input op_e              op,
  input logic [WIDTH-1:0] diff1,
  input logic [WIDTH-1:0] value_o,
  input logic             valid_o,
  input logic [IDX_W-1:0] index_o,
  input logic             ovf_o
);
  a_r2_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (index_o == '0) && valid_o && !ovf_o);

  a_r3_value_add: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADV) |=> value_o == $past(value_o + diff1));

  a_r7_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADV) |=> index_o == $past(index_o + 1'b1));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> !valid_o && $stable(value_o) && $stable(index_o));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !load_i) |=> ovf_o);

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && step_i) |=> (index_o == '0));
endmodule

bind poly_tabulator poly_tabulator_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .step_i  (step_i),
  .op      (op),
  .diff1   (diff_q[0]),
  .value_o (value_o),
  .valid_o (valid_o),
  .index_o (index_o),
  .ovf_o   (ovf_o)
);

// File: tb/tb_poly_tabulator.sv
`timescale 1ns/1ps
module tb_poly_tabulator;
  localparam int W = 32;
  localparam int MD = 6;
  localparam int IW = 16;
  localparam int DW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [W-1:0]  init_val_i = '0;
  logic [MD*W-1:0] init_diff_i = '0;
  logic [DW-1:0] degree_i = '0;
  logic          step_i = 1'b0;
  logic [W-1:0]  value_o;
  logic          valid_o;
  logic [IW-1:0] index_o;
  logic          ovf_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  poly_tabulator #(.WIDTH(W), .MAX_DEG(MD), .IDX_W(IW)) dut (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] peval(int c[7], int n);
    logic [W-1:0] acc = '0;
    for (int i = 6; i >= 0; i--) acc = acc * W'(n) + W'(c[i]);
    return acc;
  endfunction

  function automatic logic [MD*W-1:0] diffs_of(int c[7]);
    logic [W-1:0] v [7];
    logic [MD*W-1:0] r = '0;
    for (int i = 0; i < 7; i++) v[i] = peval(c, i);
    for (int o = 1; o <= 6; o++)
      for (int i = 6; i >= o; i--) v[i] = v[i] - v[i-1];
    for (int k = 1; k <= 6; k++) r[(k-1)*W +: W] = v[k];
    return r;
  endfunction

  function automatic logic sov(logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] s = a + b;
    return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
  endfunction

  task automatic do_load(logic [W-1:0] f, logic [MD*W-1:0] d, logic [DW-1:0] deg, logic with_step);
    @(negedge clk);
    load_i = 1'b1; init_val_i = f; init_diff_i = d; degree_i = deg; step_i = with_step;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic t_reset_and_preload();
    chk("R1", "value", value_o, 0);
    chk("R1", "index", index_o, 0);
    chk("R1", "valid", valid_o, 0);
    chk("R1", "ovf", ovf_o, 0);
    do_step();
    chk("R11", "valid after early step", valid_o, 0);
    chk("R11", "index after early step", index_o, 0);
    chk("R11", "value after early step", value_o, 0);
  endtask

  task automatic t_quadratic();
    logic [W-1:0] exp_seq [5] = '{41, 43, 47, 53, 61};
    logic [MD*W-1:0] d = '0;
    d[0 +: W] = 2; d[W +: W] = 2;
    do_load(41, d, 2, 1'b0);
    chk("R2", "value at load", value_o, 41);
    chk("R2", "valid at load", valid_o, 1);
    chk("R2", "index at load", index_o, 0);
    for (int n = 1; n < 5; n++) begin
      do_step();
      chk("R4", "quadratic entry", value_o, exp_seq[n]);
      chk("R7", "quadratic index", index_o, IW'(n));
    end
  endtask

  task automatic t_sixth(logic [DW-1:0] deg, string req);
    int c[7] = '{7, -3, 2, 0, 1, -1, 1};
    logic ovf_exp = 1'b0;
    do_load(peval(c, 0), diffs_of(c), deg, 1'b0);
    chk(req, "entry 0", value_o, peval(c, 0));
    for (int n = 1; n <= 64; n++) begin
      ovf_exp = ovf_exp | sov(peval(c, n-1), peval(c, n) - peval(c, n-1));
      do_step();
      chk(req, "entry", value_o, peval(c, n));
      chk("R3", "valid on step", valid_o, 1);
      chk("R9", "flag track", ovf_o, ovf_exp);
    end
  endtask

  task automatic t_degree_mask();
    logic [MD*W-1:0] d = '0;
    d[0 +: W] = 3;
    for (int k = 1; k < MD; k++) d[k*W +: W] = 32'hDEAD_0000 + W'(k);
    do_load(5, d, 1, 1'b0);
    for (int n = 1; n <= 4; n++) begin
      do_step();
      chk("R5", "linear with masked orders", value_o, W'(5 + 3*n));
    end
  endtask

  task automatic t_overflow();
    logic [MD*W-1:0] d = '0;
    d[0 +: W] = 32'h10;
    do_load(32'h7FFF_FFF0, d, 1, 1'b0);
    chk("R9", "flag clear after load", ovf_o, 0);
    do_step();
    chk("R9", "wrapped value", value_o, 32'h8000_0000);
    chk("R9", "flag set", ovf_o, 1);
    do_step();
    chk("R9", "flag held", ovf_o, 1);
    chk("R3", "value after wrap", value_o, 32'h8000_0010);
    do_load(0, d, 1, 1'b0);
    chk("R2", "flag cleared by load", ovf_o, 0);
  endtask

  task automatic t_idle();
    logic [W-1:0] v;
    logic [IW-1:0] ix;
    do_step();
    v = value_o; ix = index_o;
    repeat (3) @(negedge clk);
    chk("R8", "valid idle", valid_o, 0);
    chk("R8", "value idle", value_o, v);
    chk("R8", "index idle", index_o, ix);
  endtask

  task automatic t_priority();
    logic [MD*W-1:0] d = '0;
    d[0 +: W] = 1;
    do_step();
    do_load(100, d, 1, 1'b1);
    chk("R10", "value", value_o, 100);
    chk("R10", "index", index_o, 0);
    chk("R7", "index reset on load", index_o, 0);
    do_step();
    chk("R10", "following step", value_o, 101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_preload();
    t_quadratic();
    t_sixth(3'd6, "R4");
    t_sixth(3'd7, "R6");
    t_degree_mask();
    t_overflow();
    t_idle();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule